// File: doc/BRIEF.md
# Shared Core Duty Governor

This block sets the run state and clock duty of a single core that two hardware threads share. A latched catastrophic over-temperature flag stops the core outright. The automatic trip flag and a software throttle register for each thread can each ask for a reduced duty. The block combines all of these into one halt output and one clock-enable stream, and both threads see the same result.

Time is divided into windows of eight cycles. At the start of each window the block picks the slowest duty that any active source asks for. It then holds the clock enable high for that many cycles and low for the rest of the window. Requests are only sampled when one window is about to end, so a window is never cut short or stretched. A status output names the source that set the duty of the window now running, or reports the halt.

Top module: `core_duty_governor`

## Requirements
- R1: When `crit_hot_i` is high at a rising clock edge, `halt_o` goes high from the next cycle. It stays high until reset, even if `crit_hot_i` drops.
- R2: While `halt_o` is high, `clk_en_o` is low and `limiter_o` reads 4, whatever the other inputs are.
- R3: When the trip flag `trip_hot_i` is active, it asks for a duty of 4 enabled cycles in each 8-cycle window.
- R4: Thread t asks for a duty of N enabled cycles per window when `sw_en_i[t]` is set. N is taken from `sw_duty_i[3t+2:3t]` and must be 1 to 7. An enabled thread whose field is 0 makes no request.
- R5: In each 8-cycle window, `clk_en_o` is high for the first D cycles and low for the remaining 8-D cycles, where D is the applied duty. With no active request, D is 8. Windows follow one another with no gap, and the first window begins in the first cycle after reset is released.
- R6: The applied duty is the smallest of all active requests. On a tie, the source is chosen in this order: trip first, then thread 0, then thread 1.
- R7: Requests are sampled only at the clock edge that ends a window. A change in the middle of a window has no effect until the next window starts.
- R8: `limiter_o` names the source of the window now running: 0 none, 1 trip, 2 thread 0, 3 thread 1, 4 halt.
- R9: While reset is held, `halt_o` is low, `clk_en_o` is high and `limiter_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_hot_i | input | 1 | Catastrophic over-temperature flag |
| trip_hot_i | input | 1 | Automatic thermal trip flag |
| sw_en_i | input | 2 | Per-thread software throttle enables |
| sw_duty_i | input | 6 | Per-thread 3-bit duty fields, thread t at bits 3t+2:3t |
| halt_o | output | 1 | Core halted (sticky) |
| clk_en_o | output | 1 | Shared core clock enable |
| limiter_o | output | 3 | Source setting the current window |

## Verification
The hardest case to reach from the ports is a request that changes in the middle of a window, in a cycle where it would lower the duty if it were obeyed at once. A second hard case is the collision of two equal duties, where only the tie order decides which source is reported. Random stimulus holds each input set for a random number of cycles, so changes land at every phase of the window. Directed steps then force exact ties between the trip and thread 0, ties between the two threads, and an enabled thread with a zero field. A one-cycle catastrophic pulse at the end is followed by more random traffic to show that the halt stays in place.

// File: rtl/cmod_pkg.sv
package cmod_pkg;
  localparam int unsigned WIN_BITS   = 3;
  localparam int unsigned N_THR      = 2;
  localparam int unsigned TRIP_DUTY  = 4;
  localparam int unsigned SRC_W      = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_TRIP = 3'd1,
    SRC_SW0  = 3'd2,
    SRC_SW1  = 3'd3,
    SRC_HALT = 3'd4
  } src_e;
endpackage

// File: rtl/cmod_halt_latch.sv
module cmod_halt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic crit_i,
  output logic halt_o
);
  logic halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      halt_q <= 1'b0;
    else if (crit_i) halt_q <= 1'b1;
  end

  assign halt_o = halt_q;
endmodule

// File: rtl/cmod_req_select.sv
module cmod_req_select #(
  parameter int unsigned WB    = cmod_pkg::WIN_BITS,
  parameter int unsigned NT    = cmod_pkg::N_THR,
  parameter int unsigned TDUTY = cmod_pkg::TRIP_DUTY
) (
  input  logic                      trip_i,
  input  logic [NT-1:0]             en_i,
  input  logic [NT*WB-1:0]          duty_i,
  output logic [WB:0]               duty_o,
  output logic [cmod_pkg::SRC_W-1:0] src_o
);
  import cmod_pkg::*;

  localparam logic [WB:0] FULL_DUTY = {1'b1, {WB{1'b0}}};
  localparam logic [WB:0] TRIP_VAL  = (WB+1)'(TDUTY);

  logic [NT-1:0] req_ok;
  logic [WB:0]   req_duty [NT];

  // Per-thread slice and validity: a zero field is no request.
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [WB-1:0] fld;
    assign fld         = duty_i[t*WB +: WB];
    assign req_ok[t]   = en_i[t] && (fld != '0);
    assign req_duty[t] = {1'b0, fld};
  end

  // Minimum search; strict compare keeps earlier sources on ties.
  always_comb begin
    duty_o = FULL_DUTY;
    src_o  = SRC_NONE;
    if (trip_i) begin
      duty_o = TRIP_VAL;
      src_o  = SRC_TRIP;
    end
    for (int t = 0; t < int'(NT); t++) begin
      if (req_ok[t] && (req_duty[t] < duty_o)) begin
        duty_o = req_duty[t];
        src_o  = SRC_W'(int'(SRC_SW0) + t);
      end
    end
  end
endmodule

// File: rtl/cmod_window.sv
module cmod_window #(
  parameter int unsigned WB = cmod_pkg::WIN_BITS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WB:0]                next_duty_i,
  input  logic [cmod_pkg::SRC_W-1:0] next_src_i,
  output logic                       run_o,
  output logic [cmod_pkg::SRC_W-1:0] src_o
);
  import cmod_pkg::*;

  localparam logic [WB:0] FULL_DUTY = {1'b1, {WB{1'b0}}};

  logic [WB-1:0]       phase_q;
  logic [WB:0]         duty_q;
  logic [SRC_W-1:0]    src_q;
  logic                last_cyc;

  assign last_cyc = &phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      duty_q  <= FULL_DUTY;
      src_q   <= SRC_NONE;
    end else begin
      phase_q <= phase_q + 1'b1;
      if (last_cyc) begin
        duty_q <= next_duty_i;
        src_q  <= next_src_i;
      end
    end
  end

  assign run_o = ({1'b0, phase_q} < duty_q);
  assign src_o = src_q;
endmodule

// File: rtl/core_duty_governor.sv
module core_duty_governor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crit_hot_i,
  input  logic       trip_hot_i,
  input  logic [1:0] sw_en_i,
  input  logic [5:0] sw_duty_i,
  output logic       halt_o,
  output logic       clk_en_o,
  output logic [2:0] limiter_o
);
  import cmod_pkg::*;

  logic             halted;
  logic [WIN_BITS:0] sel_duty;
  logic [SRC_W-1:0] sel_src;
  logic             win_run;
  logic [SRC_W-1:0] win_src;

  cmod_halt_latch u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .crit_i (crit_hot_i),
    .halt_o (halted)
  );

  cmod_req_select #(
    .WB    (WIN_BITS),
    .NT    (N_THR),
    .TDUTY (TRIP_DUTY)
  ) u_sel (
    .trip_i (trip_hot_i),
    .en_i   (sw_en_i),
    .duty_i (sw_duty_i),
    .duty_o (sel_duty),
    .src_o  (sel_src)
  );

  cmod_window #(
    .WB (WIN_BITS)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .next_duty_i (sel_duty),
    .next_src_i  (sel_src),
    .run_o       (win_run),
    .src_o       (win_src)
  );

  assign halt_o    = halted;
  assign clk_en_o  = win_run && !halted;
  assign limiter_o = halted ? SRC_HALT : win_src;
endmodule

// File: rtl/cmod_checker.sv
module cmod_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       crit_hot_i,
  input logic       halt_o,
  input logic       clk_en_o,
  input logic [2:0] limiter_o
);
  logic [2:0] ck_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) ck_phase <= '0;
    else        ck_phase <= ck_phase + 1'b1;
  end

  a_r1_halt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    crit_hot_i |=> halt_o);

  a_r1_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> halt_o);

  a_r2_halt_gates: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (!clk_en_o && limiter_o == 3'd4));

  a_r3_trip_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (limiter_o == 3'd1 && ck_phase >= 3'd4) |-> !clk_en_o);

  a_r5_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o && ck_phase != 3'd0) |-> $past(clk_en_o));

  a_r7_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_phase != 3'd0 && !halt_o) |-> $stable(limiter_o));

  a_r8_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    limiter_o <= 3'd4);
endmodule

bind core_duty_governor cmod_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .crit_hot_i (crit_hot_i),
  .halt_o     (halt_o),
  .clk_en_o   (clk_en_o),
  .limiter_o  (limiter_o)
);

// File: tb/sim_core_duty_governor.sv
`timescale 1ns/1ps
module sim_core_duty_governor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       crit_hot_i, trip_hot_i;
  logic [1:0] sw_en_i;
  logic [5:0] sw_duty_i;
  logic       halt_o, clk_en_o;
  logic [2:0] limiter_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  core_duty_governor u0 (
    .clk(clk), .rst_n(rst_n), .crit_hot_i(crit_hot_i), .trip_hot_i(trip_hot_i),
    .sw_en_i(sw_en_i), .sw_duty_i(sw_duty_i),
    .halt_o(halt_o), .clk_en_o(clk_en_o), .limiter_o(limiter_o)
  );

  // Reference model built from the requirements.
  bit       m_halt;
  int       m_phase, m_duty, m_src;

  function automatic void pick(input bit trip, input bit [1:0] en, input bit [5:0] d,
                               output int duty, output int src);
    int f;
    duty = 8; src = 0;
    if (trip) begin duty = 4; src = 1; end
    for (int t = 0; t < 2; t++) begin
      f = (d >> (3*t)) & 7;
      if (en[t] && f != 0 && f < duty) begin duty = f; src = 2 + t; end
    end
  endfunction

  always @(posedge clk) begin
    int nd, ns;
    if (!rst_n) begin
      m_halt <= 0; m_phase <= 0; m_duty <= 8; m_src <= 0;
    end else begin
      if (crit_hot_i) m_halt <= 1;
      m_phase <= (m_phase + 1) % 8;
      if (m_phase == 7) begin
        pick(trip_hot_i, sw_en_i, sw_duty_i, nd, ns);
        m_duty <= nd; m_src <= ns;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string src_tag(input int s);
    case (s)
      1:       return "R3 R6";
      2, 3:    return "R4 R6";
      default: return "R5";
    endcase
  endfunction

  // Compare at the falling edge, then drive the next inputs.
  task automatic step(input bit trip, input bit [1:0] en, input bit [5:0] d, input bit crit);
    @(negedge clk);
    if (m_halt) begin
      chk("R1 halt", halt_o, 1);
      chk("R2 clk_en", clk_en_o, 0);
      chk("R2 limiter", limiter_o, 4);
    end else begin
      chk("R1 halt", halt_o, 0);
      chk({src_tag(m_src), " R7 clk_en"}, clk_en_o, (m_phase < m_duty) ? 1 : 0);
      chk("R8 limiter", limiter_o, m_src);
    end
    trip_hot_i = trip; sw_en_i = en; sw_duty_i = d; crit_hot_i = crit;
  endtask

  task automatic hold(input int n, input bit trip, input bit [1:0] en, input bit [5:0] d);
    for (int i = 0; i < n; i++) step(trip, en, d, 1'b0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    bit       r_trip;
    bit [1:0] r_en;
    bit [5:0] r_d;
    int       left;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; crit_hot_i = 0; trip_hot_i = 1; sw_en_i = 2'b11; sw_duty_i = 6'o11;
    repeat (3) @(negedge clk);
    chk("R9 halt", halt_o, 0);
    chk("R9 clk_en", clk_en_o, 1);
    chk("R9 limiter", limiter_o, 0);
    trip_hot_i = 0; sw_en_i = 0; sw_duty_i = 0;
    rst_n = 1;
    hold(16, 0, 2'b00, 6'o00);     // R5 full speed
    hold(16, 1, 2'b00, 6'o00);     // R3 trip alone
    hold(16, 0, 2'b01, 6'o70);     // R4 zero field on thread 0 ignored
    hold(16, 1, 2'b01, 6'o04);     // R6 tie trip vs thread 0
    hold(16, 0, 2'b11, 6'o22);     // R6 tie thread 0 vs thread 1
    hold(16, 1, 2'b11, 6'o17);     // thread 1 at 1 wins
    hold(3,  0, 2'b00, 6'o00);
    hold(2,  0, 2'b01, 6'o01);     // R7 mid-window change
    hold(19, 0, 2'b10, 6'o70);
    left = 0;
    for (int c = 0; c < 3000; c++) begin
      if (left == 0) begin
        r_trip = ($urandom_range(0, 2) == 0);
        r_en   = 2'($urandom);
        r_d    = 6'($urandom);
        left   = $urandom_range(1, 12);
      end
      left--;
      step(r_trip, r_en, r_d, 1'b0);
    end
    step(0, 2'b00, 6'o00, 1'b1);   // R1 one-cycle catastrophic pulse
    for (int c = 0; c < 40; c++) step($urandom_range(0, 1), 2'($urandom), 6'($urandom), 1'b0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end
endmodule